// File: doc/BRIEF.md
# PTP Event Frame Timestamp Snapshot

This block sits beside one Ethernet channel. It observes the receive and transmit byte streams and keeps one time snapshot for each direction. When a start-of-frame delimiter strobe arrives, the block records the current system time as a provisional stamp. It then reads the frame as it passes. The stamp becomes the snapshot and that direction locks only when the frame is an IPv4 UDP event message to port 319 and its message type is the one that matters for the channel's role. The role is set by a master/slave bit. For the receive direction the block also records the sender UUID and the sequence number of the locking message.

A second mode, selected by the all-frames bit, stamps every frame in both directions at its delimiter. In that mode nothing locks. Software reads a locked snapshot and then pulses that direction's clear input to release it. Each stream input uses valid/ready. The block is a passive tap, so ready is held high and it never applies back-pressure. A byte counts when valid and ready are both high in a cycle that has no delimiter strobe, and idle cycles may fall anywhere inside a frame.

Top module: `ptp_snap`

## Requirements
- R1: After reset, both snapshots, both lock flags, the UUID and the sequence number are zero. A UUID of zero means nothing has been captured.
- R2: With all_frames high, a delimiter strobe in a direction loads that direction's snapshot with the system time of that cycle, visible the next cycle. Both lock flags read 0 and the UUID and sequence are not updated.
- R3: Frame bytes count from 0, the first byte after the delimiter. A frame qualifies only if byte 14 is 0x45, bytes 36 and 37 are 0x01 and 0x3F (UDP destination port 319, high byte first), and the low nibble of byte 42 holds the wanted message type, where 0 is Sync and 1 is Delay_Req. Any other frame leaves all outputs unchanged.
- R4: With master_mode low, a qualifying received Sync (type 0) and a qualifying transmitted Delay_Req (type 1) each lock their own direction. The snapshot takes the system time of the frame's delimiter cycle. Snapshot and lock both change in the cycle after byte 73 is accepted.
- R5: With master_mode high, the wanted types swap: a received Delay_Req (type 1) and a transmitted Sync (type 0).
- R6: When the receive side locks, the UUID output takes bytes 64..69 (byte 64 most significant) and the sequence output takes bytes 72..73 (byte 72 most significant).
- R7: A locked direction keeps its snapshot and ignores later qualifying frames until its clear input is pulsed. The lock then reads 0 on the next cycle and the snapshot value is kept.
- R8: A frame cut short by a new delimiter before byte 73 discards its provisional stamp and leaves the lock state unchanged.
- R9: rx_ready and tx_ready are always 1. A cycle with valid low, or with the delimiter strobe high, carries no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| systime | input | TS_W | Current system time |
| master_mode | input | 1 | 1 = master role, 0 = slave role |
| all_frames | input | 1 | Stamp every frame and never lock |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Receive ready, always 1 |
| rx_sfd | input | 1 | Receive start-of-frame delimiter strobe |
| rx_data | input | 8 | Receive byte |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Transmit ready, always 1 |
| tx_sfd | input | 1 | Transmit start-of-frame delimiter strobe |
| tx_data | input | 8 | Transmit byte |
| rx_lock_clr | input | 1 | Pulse to release the receive lock |
| tx_lock_clr | input | 1 | Pulse to release the transmit lock |
| rx_snap | output | TS_W | Receive snapshot |
| rx_locked | output | 1 | Receive snapshot locked |
| tx_snap | output | TS_W | Transmit snapshot |
| tx_locked | output | 1 | Transmit snapshot locked |
| rx_uuid | output | 48 | Captured sender UUID |
| rx_seq | output | 16 | Captured sequence number |

## Verification
The assertions assume that the mode bits do not change inside a lock window, so that a locked, uncleared, not-all-frames direction is stable over the next cycle. They also assume that a lock can only rise on an accepted byte. The stimulus changes master_mode and all_frames only between frames, while the streams are idle. It pulses a clear only when no frame is ending. It drives every input at the falling edge. The reference model tracks bytes since each delimiter in a queue and judges a frame once it holds 74 bytes.

// File: rtl/ptp_snap_pkg.sv
package ptp_snap_pkg;
  localparam int OFS_IPVER   = 14;
  localparam int OFS_PORT_HI = 36;
  localparam int OFS_PORT_LO = 37;
  localparam int OFS_TYPE    = 42;
  localparam int OFS_UUID0   = 64;
  localparam int UUID_BYTES  = 6;
  localparam int OFS_SEQ_HI  = 72;
  localparam int OFS_LAST    = 73;
  localparam logic [7:0]  IPV4_TAG   = 8'h45;
  localparam logic [15:0] EVENT_PORT = 16'd319;
  typedef enum logic [3:0] {MSG_SYNC = 4'd0, MSG_DREQ = 4'd1} ptp_msg_e;
endpackage

// File: rtl/ptp_frame_parser.sv
module ptp_frame_parser
  import ptp_snap_pkg::*;
#(
  parameter int TS_W  = 64,
  parameter int IDX_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sfd,
  input  logic            vld,
  input  logic [7:0]      data,
  input  logic [TS_W-1:0] systime,
  input  logic [3:0]      want_type,
  output logic            commit,
  output logic [TS_W-1:0] prov_ts
);
  localparam logic [IDX_W-1:0] I_MAX  = {IDX_W{1'b1}};
  localparam logic [IDX_W-1:0] I_IP   = IDX_W'(OFS_IPVER);
  localparam logic [IDX_W-1:0] I_PH   = IDX_W'(OFS_PORT_HI);
  localparam logic [IDX_W-1:0] I_PL   = IDX_W'(OFS_PORT_LO);
  localparam logic [IDX_W-1:0] I_TY   = IDX_W'(OFS_TYPE);
  localparam logic [IDX_W-1:0] I_LAST = IDX_W'(OFS_LAST);

  logic [IDX_W-1:0] idx;
  logic             ok;
  logic             beat;
  logic             field_ok;

  assign beat = vld && !sfd;

  always_comb begin
    if (idx == I_IP)      field_ok = (data == IPV4_TAG);
    else if (idx == I_PH) field_ok = (data == EVENT_PORT[15:8]);
    else if (idx == I_PL) field_ok = (data == EVENT_PORT[7:0]);
    else if (idx == I_TY) field_ok = (data[3:0] == want_type);
    else                  field_ok = 1'b1;
  end

  assign commit = beat && ok && field_ok && (idx == I_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= '0;
      ok      <= 1'b0;
      prov_ts <= '0;
    end else if (sfd) begin
      idx     <= '0;
      ok      <= 1'b1;
      prov_ts <= systime;
    end else if (beat) begin
      if (idx != I_MAX) idx <= idx + 1'b1;
      ok <= ok && field_ok && (idx != I_LAST);
    end
  end
endmodule

// File: rtl/ptp_id_grab.sv
module ptp_id_grab
  import ptp_snap_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sfd,
  input  logic        vld,
  input  logic [7:0]  data,
  output logic [47:0] uuid_sh,
  output logic [15:0] seq_now
);
  localparam logic [IDX_W-1:0] I_MAX = {IDX_W{1'b1}};
  localparam logic [IDX_W-1:0] I_U0  = IDX_W'(OFS_UUID0);
  localparam logic [IDX_W-1:0] I_UN  = IDX_W'(OFS_UUID0 + UUID_BYTES - 1);
  localparam logic [IDX_W-1:0] I_SH  = IDX_W'(OFS_SEQ_HI);

  logic [IDX_W-1:0] idx;
  logic [7:0]       seq_hi;

  assign seq_now = {seq_hi, data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= '0;
      uuid_sh <= '0;
      seq_hi  <= '0;
    end else if (sfd) begin
      idx <= '0;
    end else if (vld) begin
      if (idx != I_MAX) idx <= idx + 1'b1;
      if (idx >= I_U0 && idx <= I_UN) uuid_sh <= {uuid_sh[39:0], data};
      if (idx == I_SH) seq_hi <= data;
    end
  end
endmodule

// File: rtl/ptp_snap_reg.sv
module ptp_snap_reg #(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            all_mode,
  input  logic            sfd,
  input  logic [TS_W-1:0] systime,
  input  logic            commit,
  input  logic [TS_W-1:0] prov_ts,
  input  logic            clr,
  output logic [TS_W-1:0] snap,
  output logic            locked,
  output logic            took
);
  assign took = commit && !all_mode && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap   <= '0;
      locked <= 1'b0;
    end else begin
      if (all_mode && sfd) snap <= systime;
      else if (took)       snap <= prov_ts;
      if (all_mode)        locked <= 1'b0;
      else if (took)       locked <= 1'b1;
      else if (clr)        locked <= 1'b0;
    end
  end

  p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !clr && !all_mode |=> locked);
  p_snap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !clr && !all_mode |=> $stable(snap));
  p_all_unlocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    all_mode |=> !locked);
  p_lock_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> !$past(all_mode) && $past(commit));
endmodule

// File: rtl/ptp_snap.sv
module ptp_snap
  import ptp_snap_pkg::*;
#(
  parameter int TS_W  = 64,
  parameter int IDX_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] systime,
  input  logic            master_mode,
  input  logic            all_frames,
  input  logic            rx_valid,
  output logic            rx_ready,
  input  logic            rx_sfd,
  input  logic [7:0]      rx_data,
  input  logic            tx_valid,
  output logic            tx_ready,
  input  logic            tx_sfd,
  input  logic [7:0]      tx_data,
  input  logic            rx_lock_clr,
  input  logic            tx_lock_clr,
  output logic [TS_W-1:0] rx_snap,
  output logic            rx_locked,
  output logic [TS_W-1:0] tx_snap,
  output logic            tx_locked,
  output logic [47:0]     rx_uuid,
  output logic [15:0]     rx_seq
);
  logic [3:0]      rx_want, tx_want;
  logic            rx_commit, tx_commit, rx_took, tx_took;
  logic [TS_W-1:0] rx_prov, tx_prov;
  logic [47:0]     uuid_sh;
  logic [15:0]     seq_now;
  logic            rx_beat;

  assign rx_ready = 1'b1;
  assign tx_ready = 1'b1;
  assign rx_beat  = rx_valid && rx_ready && !rx_sfd;
  assign rx_want  = master_mode ? MSG_DREQ : MSG_SYNC;
  assign tx_want  = master_mode ? MSG_SYNC : MSG_DREQ;

  ptp_frame_parser #(.TS_W(TS_W), .IDX_W(IDX_W)) u_rx_parse (
    .clk, .rst_n, .sfd(rx_sfd), .vld(rx_valid && rx_ready), .data(rx_data),
    .systime, .want_type(rx_want), .commit(rx_commit), .prov_ts(rx_prov));

  ptp_frame_parser #(.TS_W(TS_W), .IDX_W(IDX_W)) u_tx_parse (
    .clk, .rst_n, .sfd(tx_sfd), .vld(tx_valid && tx_ready), .data(tx_data),
    .systime, .want_type(tx_want), .commit(tx_commit), .prov_ts(tx_prov));

  ptp_id_grab #(.IDX_W(IDX_W)) u_rx_id (
    .clk, .rst_n, .sfd(rx_sfd), .vld(rx_beat), .data(rx_data),
    .uuid_sh, .seq_now);

  ptp_snap_reg #(.TS_W(TS_W)) u_rx_snap (
    .clk, .rst_n, .all_mode(all_frames), .sfd(rx_sfd), .systime,
    .commit(rx_commit), .prov_ts(rx_prov), .clr(rx_lock_clr),
    .snap(rx_snap), .locked(rx_locked), .took(rx_took));

  ptp_snap_reg #(.TS_W(TS_W)) u_tx_snap (
    .clk, .rst_n, .all_mode(all_frames), .sfd(tx_sfd), .systime,
    .commit(tx_commit), .prov_ts(tx_prov), .clr(tx_lock_clr),
    .snap(tx_snap), .locked(tx_locked), .took(tx_took));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_uuid <= '0;
      rx_seq  <= '0;
    end else if (rx_took) begin
      rx_uuid <= uuid_sh;
      rx_seq  <= seq_now;
    end
  end

  p_rx_take_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_took |-> rx_valid && !rx_sfd);
  p_tx_take_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_took |-> tx_valid && !tx_sfd);
  p_id_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_took |=> $stable(rx_uuid) && $stable(rx_seq));
  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready && tx_ready);
endmodule

// File: tb/ptp_snap_tb.sv
module ptp_snap_tb;
  localparam int PERIOD = 10;
  localparam int TS_W = 64;

  logic clk = 0, rst_n = 0;
  logic [TS_W-1:0] systime = 64'h1000;
  logic master_mode = 0, all_frames = 0;
  logic rx_valid = 0, rx_sfd = 0, tx_valid = 0, tx_sfd = 0;
  logic [7:0] rx_data = 0, tx_data = 0;
  logic rx_lock_clr = 0, tx_lock_clr = 0;
  logic rx_ready, tx_ready, rx_locked, tx_locked;
  logic [TS_W-1:0] rx_snap, tx_snap;
  logic [47:0] rx_uuid;
  logic [15:0] rx_seq;

  int total = 0, bad = 0;
  bit live = 0;

  ptp_snap u_dut (.clk, .rst_n, .systime, .master_mode, .all_frames,
    .rx_valid, .rx_ready, .rx_sfd, .rx_data, .tx_valid, .tx_ready, .tx_sfd,
    .tx_data, .rx_lock_clr, .tx_lock_clr, .rx_snap, .rx_locked, .tx_snap,
    .tx_locked, .rx_uuid, .rx_seq);

  always #(PERIOD/2) clk = ~clk;
  always @(negedge clk) systime <= systime + 64'd7;

  // reference model
  logic [7:0] rq[$], tq[$];
  logic [TS_W-1:0] r_ts = 0, t_ts = 0, m_rsnap = 0, m_tsnap = 0;
  logic m_rlock = 0, m_tlock = 0;
  logic [47:0] m_uuid = 0;
  logic [15:0] m_seq = 0;
  bit r_arm = 0, t_arm = 0;

  function automatic bit qual(input logic [7:0] q[$], input logic [3:0] want);
    return q[14] == 8'h45 && q[36] == 8'h01 && q[37] == 8'h3F && q[42][3:0] == want;
  endfunction

  always @(posedge clk) begin
    bit r_take, t_take;
    r_take = 0; t_take = 0;
    if (!rst_n) begin
      m_rsnap = 0; m_tsnap = 0; m_rlock = 0; m_tlock = 0;
      m_uuid = 0; m_seq = 0; r_arm = 0; t_arm = 0;
    end else begin
      if (rx_sfd) begin rq.delete(); r_ts = systime; r_arm = 1; end
      else if (rx_valid && r_arm) begin
        rq.push_back(rx_data);
        if (rq.size() == 74) begin
          r_arm = 0;
          r_take = !all_frames && !m_rlock && qual(rq, master_mode ? 4'd1 : 4'd0);
        end
      end
      if (tx_sfd) begin tq.delete(); t_ts = systime; t_arm = 1; end
      else if (tx_valid && t_arm) begin
        tq.push_back(tx_data);
        if (tq.size() == 74) begin
          t_arm = 0;
          t_take = !all_frames && !m_tlock && qual(tq, master_mode ? 4'd0 : 4'd1);
        end
      end
      if (all_frames && rx_sfd) m_rsnap = systime; else if (r_take) m_rsnap = r_ts;
      if (all_frames && tx_sfd) m_tsnap = systime; else if (t_take) m_tsnap = t_ts;
      if (all_frames) m_rlock = 0; else if (r_take) m_rlock = 1; else if (rx_lock_clr) m_rlock = 0;
      if (all_frames) m_tlock = 0; else if (t_take) m_tlock = 1; else if (tx_lock_clr) m_tlock = 0;
      if (r_take) begin
        m_uuid = {rq[64], rq[65], rq[66], rq[67], rq[68], rq[69]};
        m_seq = {rq[72], rq[73]};
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (live) begin
    chk("R4 rx_snap", rx_snap, m_rsnap);
    chk("R5 tx_snap", tx_snap, m_tsnap);
    chk("R7 rx_locked", {63'd0, rx_locked}, {63'd0, m_rlock});
    chk("R7 tx_locked", {63'd0, tx_locked}, {63'd0, m_tlock});
    chk("R6 rx_uuid", {16'd0, rx_uuid}, {16'd0, m_uuid});
    chk("R6 rx_seq", {48'd0, rx_seq}, {48'd0, m_seq});
    chk("R9 ready", {62'd0, rx_ready, tx_ready}, 64'd3);
  end

  logic [7:0] fq[$];
  task automatic mk(input logic [7:0] ipb, input logic [15:0] port, input logic [3:0] ty,
                    input logic [47:0] uu, input logic [15:0] sq, input int len);
    fq.delete();
    for (int i = 0; i < len; i++) fq.push_back(8'((i * 5 + 3) & 8'hFF));
    fq[14] = ipb; fq[36] = port[15:8]; fq[37] = port[7:0];
    fq[42] = {4'h1, ty};
    for (int i = 0; i < 6; i++) fq[64 + i] = uu[47 - 8*i -: 8];
    fq[72] = sq[15:8]; fq[73] = sq[7:0];
  endtask

  task automatic send(input bit tx, input int gap);
    @(negedge clk);
    if (tx) begin tx_sfd = 1; tx_valid = 1; end else begin rx_sfd = 1; rx_valid = 1; end
    for (int i = 0; i < fq.size(); i++) begin
      @(negedge clk);
      tx_sfd = 0; rx_sfd = 0;
      if (gap > 0 && i % gap == 1) begin
        rx_valid = 0; tx_valid = 0;
        @(negedge clk);
      end
      if (tx) begin tx_valid = 1; tx_data = fq[i]; end
      else begin rx_valid = 1; rx_data = fq[i]; end
    end
    @(negedge clk);
    rx_valid = 0; tx_valid = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_clr(input bit tx);
    @(negedge clk);
    if (tx) tx_lock_clr = 1; else rx_lock_clr = 1;
    @(negedge clk);
    tx_lock_clr = 0; rx_lock_clr = 0;
    @(negedge clk);
  endtask

  task automatic finish_up;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset rx_snap", rx_snap, 0);
    chk("R1 reset uuid", {16'd0, rx_uuid}, 0);
    rst_n = 1;
    @(negedge clk);
    live = 1;
    chk("R1 reset locks", {62'd0, rx_locked, tx_locked}, 0);
    chk("R9 ready high", {62'd0, rx_ready, tx_ready}, 3);
    // R3 rejections in slave mode
    mk(8'h60, 16'd319, 4'd0, 48'hA1A2A3A4A5A6, 16'h1234, 80); send(0, 0);
    chk("R3 ipv6 ignored", {63'd0, rx_locked}, 0);
    mk(8'h45, 16'd320, 4'd0, 48'hA1A2A3A4A5A6, 16'h1234, 80); send(0, 0);
    chk("R3 port ignored", {63'd0, rx_locked}, 0);
    mk(8'h45, 16'd319, 4'd1, 48'hA1A2A3A4A5A6, 16'h1234, 80); send(0, 0);
    chk("R3 wrong type ignored", {63'd0, rx_locked}, 0);
    chk("R1 uuid zero still", {16'd0, rx_uuid}, 0);
    // R4 slave lock with gaps (R9)
    mk(8'h45, 16'd319, 4'd0, 48'h0123456789AB, 16'hBEEF, 74); send(0, 7);
    chk("R4 rx lock", {63'd0, rx_locked}, 1);
    chk("R4 rx snap at sfd", rx_snap, r_ts);
    chk("R6 uuid", {16'd0, rx_uuid}, 64'h0123456789AB);
    chk("R6 seq", {48'd0, rx_seq}, 64'hBEEF);
    // R7 ignore while locked
    mk(8'h45, 16'd319, 4'd0, 48'h111111111111, 16'h2222, 90); send(0, 0);
    chk("R7 uuid kept", {16'd0, rx_uuid}, 64'h0123456789AB);
    pulse_clr(0);
    chk("R7 cleared", {63'd0, rx_locked}, 0);
    // tx side slave
    mk(8'h45, 16'd319, 4'd0, 48'h0, 16'h0, 80); send(1, 0);
    chk("R4 tx sync ignored", {63'd0, tx_locked}, 0);
    mk(8'h45, 16'd319, 4'd1, 48'h0, 16'h0, 80); send(1, 3);
    chk("R4 tx dreq locks", {63'd0, tx_locked}, 1);
    // R8 abort
    mk(8'h45, 16'd319, 4'd0, 48'h999999999999, 16'h7777, 74);
    fq = fq[0:60]; send(0, 0);
    mk(8'h45, 16'd319, 4'd0, 48'h999999999999, 16'h7777, 20); send(0, 0);
    chk("R8 abort no lock", {63'd0, rx_locked}, 0);
    pulse_clr(1);
    // R5 master
    master_mode = 1;
    mk(8'h45, 16'd319, 4'd0, 48'h555555555555, 16'h0001, 80); send(0, 0);
    chk("R5 rx sync ignored", {63'd0, rx_locked}, 0);
    mk(8'h45, 16'd319, 4'd1, 48'hCAFEF00D0001, 16'h0042, 80); send(0, 0);
    chk("R5 rx dreq locks", {63'd0, rx_locked}, 1);
    chk("R5 uuid", {16'd0, rx_uuid}, 64'hCAFEF00D0001);
    mk(8'h45, 16'd319, 4'd0, 48'h0, 16'h0, 80); send(1, 0);
    chk("R5 tx sync locks", {63'd0, tx_locked}, 1);
    // R2 all frames
    @(negedge clk); all_frames = 1; @(negedge clk);
    chk("R2 unlocked", {62'd0, rx_locked, tx_locked}, 0);
    mk(8'h60, 16'd1, 4'd7, 48'h0, 16'h0, 30); send(0, 0);
    chk("R2 rx stamp", rx_snap, r_ts);
    send(1, 0);
    chk("R2 tx stamp", tx_snap, t_ts);
    mk(8'h45, 16'd319, 4'd1, 48'h777777777777, 16'h0009, 80); send(0, 0);
    chk("R2 no lock no id", {16'd0, rx_uuid}, 64'hCAFEF00D0001);
    @(negedge clk); all_frames = 0; master_mode = 0;
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule